// File: doc/BRIEF.md
# Line activity receive trigger

This block watches a line while the receiver is idle and decides when a packet is arriving. Each accepted edge pulse stores the current value of a free-running time counter in a small circular store. The store holds the most recent `EDGES` timestamps. When a new edge arrives, its time is compared with the oldest stored timestamp, so the test covers a span of `EDGES` edges including the new one. If that span is shorter than the window on `win_len`, the block pulses `start_rx` to launch the receive decoder.

After it triggers, the block masks itself (`rx_busy`) until the decoder reports `rx_done`. A transmit request is granted only while no reception is running. The block also reports the time elapsed since the most recent accepted edge, which the protocol layer can use for idle timing.

All pins are plain control and status signals. No stream handshake applies: each edge is a single-cycle event, and the block never applies back-pressure.

Top module: `rx_line_trigger`

## Requirements
- R1: After reset, `start_rx`, `rx_busy` and `tx_go` are 0 and `since_edge` reads all ones, because no edge has been recorded yet.
- R2: When an accepted edge makes the span from the oldest stored edge to the new one (covering `EDGES` edges) strictly less than `win_len`, `start_rx` is 1 for exactly the one cycle after that edge's clock edge.
- R3: A span equal to or greater than `win_len` does not trigger; the edge is still recorded.
- R4: Until `EDGES` edges have been accepted since reset, no trigger occurs, whatever their spacing.
- R5: From a trigger, `rx_busy` stays 1 until a cycle with `rx_done` = 1 and falls after that cycle; edges while busy are not recorded and cannot trigger.
- R6: An edge in the same cycle as `rx_done` is discarded; edges are accepted again from the next cycle.
- R7: `since_edge` equals `now_ts` minus the timestamp of the most recent accepted edge, modulo 2^`TS_W`, combinationally.
- R8: `tx_go` is 1 one cycle after `tx_req` was 1 in a cycle with `rx_busy` = 0 and no trigger; otherwise it is 0.
- R9: Spans are computed modulo 2^`TS_W`, so a burst across a counter wrap triggers normally.
- R10: The store slides: every accepted edge overwrites the oldest entry, and a later trigger is judged on only the latest `EDGES` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| edge_in | input | 1 | One-cycle pulse per detected line transition |
| now_ts | input | TS_W | Free-running time counter value |
| win_len | input | TS_W | Trigger window; span must be below this |
| rx_done | input | 1 | Decoder finished the current frame |
| tx_req | input | 1 | Request to start a transmission |
| start_rx | output | 1 | One-cycle pulse launching the receive decoder |
| rx_busy | output | 1 | Reception running; edge monitoring masked |
| tx_go | output | 1 | Transmission granted |
| since_edge | output | TS_W | Time since the most recent accepted edge |

## Verification
The assertions assume that `edge_in` and `rx_done` are single-cycle pulses from a synchronous source. They also assume that `win_len` changes only while no edge is present. The stimulus drives every input shortly after a rising edge and holds `win_len` constant for the whole run. Timestamps are chosen so that each span is unambiguous within one counter period. One exception is the deliberate wrap burst, which stays well below the window.

// File: rtl/rxtrig_pkg.sv
package rxtrig_pkg;
  // Advance a ring index with wrap at depth-1.
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction

  // Previous ring index with wrap to depth-1.
  function automatic int unsigned ring_prev(input int unsigned idx, input int unsigned depth);
    return (idx == 0) ? depth - 1 : idx - 1;
  endfunction
endpackage

// File: rtl/rxtrig_ring.sv
module rxtrig_ring
  import rxtrig_pkg::*;
#(
  parameter int EDGES = 4,
  parameter int TS_W  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [TS_W-1:0] wr_ts,
  output logic [TS_W-1:0] oldest_ts,
  output logic            oldest_vld,
  output logic [TS_W-1:0] last_ts,
  output logic            last_vld
);
  localparam int IDX_W = (EDGES > 1) ? $clog2(EDGES) : 1;

  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] nxt_idx;
  logic [IDX_W-1:0] prv_idx;
  logic [TS_W-1:0]  ts_q  [EDGES];
  logic [EDGES-1:0] vld_q;

  assign nxt_idx = IDX_W'(ring_next(32'(wr_idx), EDGES));
  assign prv_idx = IDX_W'(ring_prev(32'(wr_idx), EDGES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_idx <= '0;
    else if (wr_en) wr_idx <= nxt_idx;
  end

  for (genvar g = 0; g < EDGES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ts_q[g]  <= '0;
        vld_q[g] <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        ts_q[g]  <= wr_ts;
        vld_q[g] <= 1'b1;
      end
    end
  end

  assign oldest_ts  = ts_q[nxt_idx];
  assign oldest_vld = vld_q[nxt_idx];
  assign last_ts    = ts_q[prv_idx];
  assign last_vld   = vld_q[prv_idx];

  // R10: write pointer never leaves the ring
  a_r10_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(wr_idx) < EDGES);
  // R4: slots fill in order, so a valid oldest slot implies a valid newest one
  a_r4_fill_order: assert property (@(posedge clk) disable iff (!rst_n)
    oldest_vld |-> last_vld);
endmodule

// File: rtl/rxtrig_span.sv
module rxtrig_span #(
  parameter int TS_W = 16
) (
  input  logic [TS_W-1:0] new_ts,
  input  logic [TS_W-1:0] old_ts,
  input  logic            old_vld,
  input  logic [TS_W-1:0] win_len,
  output logic            hit
);
  logic [TS_W-1:0] span;

  always_comb begin
    span = new_ts - old_ts;
    hit  = old_vld && (span < win_len);
  end
endmodule

// File: rtl/rxtrig_arm.sv
module rxtrig_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_in,
  input  logic hit,
  input  logic rx_done,
  input  logic tx_req,
  output logic accept,
  output logic start_rx,
  output logic rx_busy,
  output logic tx_go
);
  logic fire;

  assign accept = edge_in && !rx_busy;
  assign fire   = accept && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_rx <= 1'b0;
      rx_busy  <= 1'b0;
      tx_go    <= 1'b0;
    end else begin
      start_rx <= fire;
      tx_go    <= tx_req && !rx_busy && !fire;
      if (rx_busy) begin
        if (rx_done) rx_busy <= 1'b0;
      end else if (fire) begin
        rx_busy <= 1'b1;
      end
    end
  end

  a_r2_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    start_rx |=> !start_rx);
  a_r5_start_masks: assert property (@(posedge clk) disable iff (!rst_n)
    start_rx |-> rx_busy);
  a_r5_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_busy && !rx_done) |=> rx_busy);
  a_r6_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_busy && rx_done) |=> (!rx_busy && !start_rx));
  a_r8_tx_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |-> !rx_busy);
endmodule

// File: rtl/rx_line_trigger.sv
module rx_line_trigger #(
  parameter int EDGES = 4,
  parameter int TS_W  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            edge_in,
  input  logic [TS_W-1:0] now_ts,
  input  logic [TS_W-1:0] win_len,
  input  logic            rx_done,
  input  logic            tx_req,
  output logic            start_rx,
  output logic            rx_busy,
  output logic            tx_go,
  output logic [TS_W-1:0] since_edge
);
  logic            accept;
  logic            hit;
  logic [TS_W-1:0] oldest_ts;
  logic            oldest_vld;
  logic [TS_W-1:0] last_ts;
  logic            last_vld;

  rxtrig_ring #(.EDGES(EDGES), .TS_W(TS_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_ts(now_ts),
    .oldest_ts(oldest_ts), .oldest_vld(oldest_vld),
    .last_ts(last_ts), .last_vld(last_vld)
  );

  rxtrig_span #(.TS_W(TS_W)) u_span (
    .new_ts(now_ts), .old_ts(oldest_ts), .old_vld(oldest_vld),
    .win_len(win_len), .hit(hit)
  );

  rxtrig_arm u_arm (
    .clk(clk), .rst_n(rst_n), .edge_in(edge_in), .hit(hit),
    .rx_done(rx_done), .tx_req(tx_req), .accept(accept),
    .start_rx(start_rx), .rx_busy(rx_busy), .tx_go(tx_go)
  );

  assign since_edge = last_vld ? (now_ts - last_ts) : '1;

  // R5: a masked edge leaves the recorded history untouched
  a_r5_masked_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_in && rx_busy) |=> $stable(last_ts));
endmodule

// File: tb/rx_line_trigger_tb.sv
module rx_line_trigger_tb;
  localparam int N   = 4;
  localparam int TW  = 16;
  localparam int WIN = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic edge_in = 1'b0;
  logic [TW-1:0] now_ts = '0;
  logic [TW-1:0] win_len = TW'(WIN);
  logic rx_done = 1'b0;
  logic tx_req = 1'b0;
  logic start_rx, rx_busy, tx_go;
  logic [TW-1:0] since_edge;

  rx_line_trigger #(.EDGES(N), .TS_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .edge_in(edge_in), .now_ts(now_ts),
    .win_len(win_len), .rx_done(rx_done), .tx_req(tx_req),
    .start_rx(start_rx), .rx_busy(rx_busy), .tx_go(tx_go),
    .since_edge(since_edge)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int at; bit exp; string tag; } exp_t;
  exp_t q[$];

  int m_ts[N];
  bit m_v[N];
  int m_w = 0;
  bit m_busy = 0;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Monitor: compare start_rx against scoreboard entries
  always @(negedge clk) begin
    if (rst_n) begin
      if (q.size() > 0 && q[0].at == cyc) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, int'(start_rx), int'(e.exp));
      end else if (start_rx) begin
        chk("R2 unexpected start_rx", 1, 0);
      end
    end
  end

  // Driver: one edge, optional rx_done in the same cycle; model predicts trigger
  task automatic drive_edge(input int t, input bit with_done, input string tag);
    bit trig;
    @(posedge clk); #2;
    now_ts = TW'(t); edge_in = 1'b1; rx_done = with_done;
    trig = 0;
    if (!m_busy) begin
      int nx;
      int diff;
      nx = (m_w == N - 1) ? 0 : m_w + 1;
      diff = (t - m_ts[nx]) & ((1 << TW) - 1);
      trig = m_v[nx] && (diff < WIN);
      m_ts[m_w] = t & ((1 << TW) - 1);
      m_v[m_w] = 1;
      m_w = nx;
    end
    if (with_done) m_busy = 0;
    if (trig) m_busy = 1;
    q.push_back('{cyc + 1, trig, tag});
    @(posedge clk); #2;
    edge_in = 1'b0; rx_done = 1'b0;
  endtask

  task automatic pulse_done();
    @(posedge clk); #2; rx_done = 1'b1; m_busy = 0;
    @(posedge clk); #2; rx_done = 1'b0;
  endtask

  task automatic chk_since(input int t, input int exp, input string tag);
    @(posedge clk); #2; now_ts = TW'(t); #1;
    chk(tag, int'(since_edge), exp);
  endtask

  task automatic chk_tx(input int exp, input string tag);
    @(posedge clk); #2; tx_req = 1'b1;
    @(posedge clk); #2; tx_req = 1'b0; #1;
    chk(tag, int'(tx_go), exp);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_ts[i] = 0; m_v[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R1 start_rx reset", int'(start_rx), 0);
    chk("R1 rx_busy reset", int'(rx_busy), 0);
    chk("R1 tx_go reset", int'(tx_go), 0);
    chk("R1 since_edge reset", int'(since_edge), 16'hFFFF);
    @(posedge clk); #2; rst_n = 1'b1;

    // R4: three close edges, store not yet full
    drive_edge(10, 0, "R4 edge1");
    drive_edge(20, 0, "R4 edge2");
    drive_edge(30, 0, "R4 edge3");
    chk_since(35, 5, "R7 since after 30");
    chk_tx(1, "R8 tx granted idle");
    // R2: fourth edge, span 30 < 100
    drive_edge(40, 0, "R2 trigger span30");
    #1; chk("R5 busy after trigger", int'(rx_busy), 1);
    // R5: masked edges
    drive_edge(45, 0, "R5 masked edge1");
    drive_edge(46, 0, "R5 masked edge2");
    chk_since(50, 10, "R5 masked edges not recorded");
    chk_tx(0, "R8 tx refused while busy");
    // R6: edge coinciding with done
    drive_edge(60, 1, "R6 edge with done");
    #1; chk("R6 busy released", int'(rx_busy), 0);
    chk_since(70, 30, "R6 coincident edge dropped");
    // R3 / R10: slow edges then boundary
    drive_edge(200, 0, "R3 slow1");
    drive_edge(300, 0, "R3 slow2");
    drive_edge(400, 0, "R3 slow3");
    drive_edge(500, 0, "R3 slow4");
    drive_edge(1000, 0, "R10 burst1");
    drive_edge(1020, 0, "R10 burst2");
    drive_edge(1040, 0, "R10 burst3");
    drive_edge(1100, 0, "R3 span equal window");
    #1; chk("R3 not busy at equal span", int'(rx_busy), 0);
    drive_edge(1119, 0, "R10 trigger span99");
    pulse_done();
    #1; chk("R5 done clears busy", int'(rx_busy), 0);
    // R9: burst across counter wrap
    drive_edge(65500, 0, "R9 wrap1");
    drive_edge(65520, 0, "R9 wrap2");
    drive_edge(65530, 0, "R9 wrap3");
    drive_edge(20, 0, "R9 trigger across wrap");
    chk_since(30, 10, "R7 since after wrap");
    pulse_done();
    repeat (3) @(posedge clk);
    #1; chk("R2 scoreboard drained", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule